// File: doc/BRIEF.md
# Modem Status and Interrupt Enable Unit

This block keeps the modem line status of one serial channel. Four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier) are passed through a two-flop synchronizer and reported as active-high level bits. Four change flags record transitions of those levels. In internal loop-back mode the levels come from four modem-control bits supplied by the channel, not from the pins. A small register port lets software read the status byte, and that read clears the change flags. The port also holds the interrupt-enable byte: three enables that are passed on to other parts of the channel (CTS, RTS and Xoff interrupts) and one that gates this block's own modem interrupt request.

A small two-state machine decides when change detection is live. After reset it is in SETTLE: the synchronizer fills, the previous-level registers track the current levels and no change flag can be set. After `SYNC_STAGES+1` clocks the transition SETTLE→RUN fires and detection starts; RUN then holds until the next reset. Addresses: 0 selects the status byte, 1 selects the interrupt-enable byte.

Top module: `modem_status_unit`

## Requirements
- R1: In normal mode, status byte bits 7, 6, 5, 4 read the complement of `cd_n`, `ri_n`, `dsr_n`, `cts_n`; a pin change shows two clocks after it is applied.
- R2: With `loop_en`=1, bit 7 equals `mcr[3]`, bit 6 equals `mcr[2]`, bit 5 equals `mcr[0]` and bit 4 equals `mcr[1]`, in the same cycle.
- R3: Status bits 3, 1, 0 are set when the carrier, data-set-ready or clear-to-send level changes in either direction, one clock after the level changes.
- R4: Status bit 2 is set only when the ring level goes from 0 to 1; a 1-to-0 change leaves it clear.
- R5: A read of address 0 returns the byte as it was and clears bits 3..0; a change detected on the clock edge of that read keeps its flag set.
- R6: After reset every change flag and every interrupt enable is 0, and no change flag appears during SETTLE, even when a pin is held asserted across reset.
- R7: A write to address 1 stores bits 7 (CTS enable), 6 (RTS enable), 5 (Xoff enable) and 3 (modem enable); reading address 1 returns those bits and 0 elsewhere, and the first three appear on `cts_irq_en`, `rts_irq_en`, `xoff_irq_en`.
- R8: `modem_irq` is 1 exactly when enable bit 3 is set and at least one change flag is set.
- R9: In loop-back mode pin changes set no change flag; the flags follow changes of the control bits, including the level step caused by entering or leaving loop-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring pin, active low, asynchronous |
| cd_n | input | 1 | Carrier pin, active low, asynchronous |
| loop_en | input | 1 | Internal loop-back select |
| mcr | input | 4 | Modem-control bits used as sources in loop-back |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_addr | input | 1 | 0 = status byte, 1 = interrupt-enable byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte |
| modem_irq | output | 1 | Modem-status interrupt request |
| cts_irq_en | output | 1 | CTS interrupt enable |
| rts_irq_en | output | 1 | RTS interrupt enable |
| xoff_irq_en | output | 1 | Xoff interrupt enable |

## Verification
The status path is driven with single-pin assertions, paired assertions and releases, which separates the per-bit pin order and shows that both edge directions set the CD, DSR and CTS flags, while a ring assert followed by a ring release tells the rising-only rule apart from an any-change rule. Loop-back is tried with control patterns whose bit order differs from the status order, so a swapped DSR/CTS mapping shows up, and pins are toggled while in loop-back to show they are ignored. A pin change timed to land on the read edge distinguishes a clear-wins design from the required set-wins one, and a pin held asserted through reset exposes a false flag during SETTLE.

// File: rtl/msr_pkg.sv
package msr_pkg;
    // phase of change detection
    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_RUN    = 1'b1
    } msr_phase_t;

    localparam int LINES = 4;
    // line index inside the 4-bit vectors
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_IEN    = 1'b1;

    // interrupt-enable byte bit positions
    localparam int IEN_CTS  = 7;
    localparam int IEN_RTS  = 6;
    localparam int IEN_XOFF = 5;
    localparam int IEN_MS   = 3;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int   WIDTH   = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    pipe[s] <= din;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level,
    input  logic             clr,
    output logic [LINES-1:0] delta,
    output logic             settling
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    msr_phase_t       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] event_raw;
    logic [LINES-1:0] event_live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions: SETTLE -> RUN after SETTLE_CYCLES edges
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (cnt_q == CW'(SETTLE_CYCLES - 1)) state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
        endcase
    end

    // per-line event detection
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_evt
            if (i == IDX_RI) begin : g_rise
                assign event_raw[i] = level[i] & ~prev_q[i];
            end else begin : g_any
                assign event_raw[i] = level[i] ^ prev_q[i];
            end
        end
    endgenerate

    // outputs of the state machine
    always_comb begin
        event_live = '0;
        settling   = 1'b0;
        unique case (state_q)
            ST_SETTLE: settling   = 1'b1;
            ST_RUN:    event_live = event_raw;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            delta  <= '0;
        end else begin
            prev_q <= level;
            delta  <= (delta & ~{LINES{clr}}) | event_live;
        end
    end
endmodule

// File: rtl/msr_ien.sv
module msr_ien
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] value
);
    localparam logic [7:0] KEEP = 8'((1 << IEN_CTS) | (1 << IEN_RTS) |
                                     (1 << IEN_XOFF) | (1 << IEN_MS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else if (wr) value <= wdata & KEEP;
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    input  logic       loop_en,
    input  logic [3:0] mcr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       modem_irq,
    output logic       cts_irq_en,
    output logic       rts_irq_en,
    output logic       xoff_irq_en
);
    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;

    logic [LINES-1:0] pins_n, pins_sync_n, loop_lvl, level;
    logic [LINES-1:0] delta_q;
    logic [7:0]       ien_q;
    logic             settling;
    logic             rd_status;

    assign pins_n = {cd_n, ri_n, dsr_n, cts_n};

    msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_n), .dout(pins_sync_n)
    );

    // loop-back routing of control bits to lines
    assign loop_lvl[IDX_CTS] = mcr[1];
    assign loop_lvl[IDX_DSR] = mcr[0];
    assign loop_lvl[IDX_RI]  = mcr[2];
    assign loop_lvl[IDX_CD]  = mcr[3];

    assign level     = loop_en ? loop_lvl : ~pins_sync_n;
    assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);

    msr_delta #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_delta (
        .clk(clk), .rst_n(rst_n), .level(level), .clr(rd_status),
        .delta(delta_q), .settling(settling)
    );

    msr_ien u_ien (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr && (reg_addr == ADDR_IEN)),
        .wdata(reg_wdata), .value(ien_q)
    );

    assign reg_rdata   = (reg_addr == ADDR_STATUS) ? {level, delta_q} : ien_q;
    assign modem_irq   = ien_q[IEN_MS] & (|delta_q);
    assign cts_irq_en  = ien_q[IEN_CTS];
    assign rts_irq_en  = ien_q[IEN_RTS];
    assign xoff_irq_en = ien_q[IEN_XOFF];
endmodule

// File: rtl/msr_chk.sv
module msr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       modem_irq,
    input logic       cts_irq_en,
    input logic [3:0] level,
    input logic [3:0] delta_q,
    input logic       settling
);
    // R4
    ri_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(level[2]) && !$past(level[2], 2)));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 1'b0 && level == $past(level)) |=> (delta_q == 4'd0));

    // R6
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> (delta_q == 4'd0));

    // R7
    ien_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b1) |=> (cts_irq_en == $past(reg_wdata[7])));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b1 && !reg_rdata[3]) |-> !modem_irq);
endmodule

bind modem_status_unit msr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .modem_irq(modem_irq), .cts_irq_en(cts_irq_en),
    .level(level), .delta_q(delta_q), .settling(settling)
);

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] mcr = 4'h0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       modem_irq, cts_irq_en, rts_irq_en, xoff_irq_en;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    modem_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .cd_n(cd_n), .loop_en(loop_en), .mcr(mcr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .modem_irq(modem_irq), .cts_irq_en(cts_irq_en),
        .rts_irq_en(rts_irq_en), .xoff_irq_en(xoff_irq_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // read a byte: value is sampled before the read edge
    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        reg_addr = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        cts_n = 1'b0;          // held asserted through reset
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(6);
        rd(1'b0, v); check("R6 status after reset", v, 8'h10);
        rd(1'b1, v); check("R6 enables after reset", v, 8'h00);
        check("R6 irq after reset", {7'd0, modem_irq}, 8'h00);
    endtask

    task automatic t_levels_and_any;
        logic [7:0] v;
        cts_n = 1'b1;
        tick(1);
        rd(1'b0, v); check("R1 level not yet synced", v[7:4], 4'h1);
        tick(2);
        rd(1'b0, v); check("R3 cts release flag", v, 8'h01);
        rd(1'b0, v); check("R5 cleared by read", v, 8'h00);
        dsr_n = 1'b0; cd_n = 1'b0;
        tick(3);
        rd(1'b0, v); check("R1 R3 cd dsr assert", v, 8'hAA);
        dsr_n = 1'b1; cd_n = 1'b1;
        tick(3);
        rd(1'b0, v); check("R3 cd dsr release", v, 8'h0A);
    endtask

    task automatic t_ring;
        logic [7:0] v;
        ri_n = 1'b0;
        tick(3);
        rd(1'b0, v); check("R4 ring rise", v, 8'h44);
        ri_n = 1'b1;
        tick(3);
        rd(1'b0, v); check("R4 ring fall no flag", v, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        cts_n = 1'b0;
        tick(2);               // level visible, flag set on next edge
        rd(1'b0, v); check("R5 read on event edge value", v, 8'h10);
        rd(1'b0, v); check("R5 event kept over clear", v, 8'h11);
        rd(1'b0, v); check("R5 cleared after", v, 8'h10);
    endtask

    task automatic t_loop;
        logic [7:0] v;
        mcr = 4'h0;
        loop_en = 1'b1;        // cts level 1 -> 0
        #1 check("R2 loop level zero", reg_rdata[7:4], 4'h0);
        tick(2);
        rd(1'b0, v); check("R9 loop entry flag", v, 8'h01);
        mcr = 4'b0001;
        tick(2);
        rd(1'b0, v); check("R2 R9 mcr0 to dsr", v, 8'h22);
        mcr = 4'b1110;
        tick(2);
        rd(1'b0, v); check("R2 R9 mcr pattern", v, 8'hDF);
        cts_n = 1'b1; cd_n = 1'b0; ri_n = 1'b0; dsr_n = 1'b0;
        tick(4);
        rd(1'b0, v); check("R9 pins ignored in loop", v, 8'hD0);
        ri_n = 1'b1; dsr_n = 1'b1;
        tick(3);
        mcr = 4'h0;
        loop_en = 1'b0;        // levels now cd only
        tick(2);
        rd(1'b0, v); check("R9 loop exit flags", v, 8'h81);
    endtask

    task automatic t_ien_irq;
        logic [7:0] v;
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R7 enable readback", v, 8'hE8);
        check("R7 enable outputs", {5'd0, cts_irq_en, rts_irq_en, xoff_irq_en}, 8'h07);
        wr(1'b1, 8'h00);
        check("R7 enables cleared", {5'd0, cts_irq_en, rts_irq_en, xoff_irq_en}, 8'h00);
        cd_n = 1'b1;
        tick(3);
        check("R8 irq gated off", {7'd0, modem_irq}, 8'h00);
        wr(1'b1, 8'h08);
        check("R8 irq with enable", {7'd0, modem_irq}, 8'h01);
        rd(1'b0, v); check("R3 cd release flag", v, 8'h08);
        check("R8 irq drops after read", {7'd0, modem_irq}, 8'h00);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_levels_and_any();
                t_ring();
                t_collision();
                t_loop();
                t_ien_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=running expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule